// File: doc/BRIEF.md
# Sequencing Delay Timer Bank

This block provides a set of independent one-shot delay timers for a power-up and power-down sequencing state machine. The state machine raises a timer's start line when it wants to wait, and moves on when the matching done line goes high. Each timer is set by a static interval code. The code is read as a small floating-point number, so a few bits span a range from tens of microseconds to about two seconds.

All timers run from one master clock, 8 MHz in the intended setting. A shared divider turns it into a coarse timing tick of 4 µs (250 kHz) by default. Each timer counts ticks through its own exponent prescaler and mantissa counter, so its expiry lands within one tick of the ideal time. The reset input asserts asynchronously and is released in step with the clock.

Top module: `seq_timer_bank`

## Requirements
- R1: A timing tick occurs once every TICK_DIV master-clock cycles. The default of 32 gives a 250 kHz tick from an 8 MHz clock.
- R2: The top EXP_W bits of a timer's code are the exponent e, and the low MAN_W bits are the mantissa m. The interval is N = (8+m)·2^e ticks when MAN_W is 3. Code 0 gives 8 ticks (32 µs by default). The all-ones default code gives 15·2^15 ticks (about 1.97 s).
- R3: A timer starts on a rising edge of its start input. Its done output rises no sooner than (N-1)·TICK_DIV+1 and no later than N·TICK_DIV clock edges after the edge that first samples start high. Done only rises on an edge that carries a tick.
- R4: Done stays high for as long as start stays high after expiry.
- R5: When start goes low, the timer returns to idle on the next edge, whether it is running or expired. Done is low after that edge, and a running interval never reaches done. A later rising edge times a full new interval.
- R6: The timers run independently. Timer i uses start bit i, done bit i and code bits [i·CODE_W +: CODE_W].
- R7: A timer captures its code on the start edge. Changes to the code while the timer runs do not change that interval.
- R8: Driving rst_n low clears every timer and the tick divider at once, so all done bits go low. A start held high through reset release counts as a fresh rising edge and times a full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (8 MHz intended) |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released in step with clk |
| start_i | input | NUM_TMR | Per-timer start/hold level |
| code_i | input | NUM_TMR·(EXP_W+MAN_W) | Packed per-timer interval codes, timer 0 in the low bits |
| done_o | output | NUM_TMR | Per-timer expiry flag |

## Verification
The bench builds the bank with TICK_DIV = 4 and EXP_W = 3, keeping four timers and a 3-bit mantissa. The shorter tick and the narrower exponent bring the all-ones code (1920 ticks) within a few thousand cycles, so the longest interval can be timed edge for edge next to the shortest and a middle one. The tick window still spans several clock cycles, so the bounds of R3 can tell a late count from an early one. These settings also leave room for abort, restart, code capture and reset-release cases.

// File: rtl/seq_tmr_pkg.sv
package seq_tmr_pkg;

  // Life cycle of one delay timer
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_DONE = 2'd2
  } tmr_state_e;

endpackage

// File: rtl/seq_rst_sync.sv
// Asynchronous assertion, clocked two-stage release.
module seq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;

endmodule

// File: rtl/seq_tick_div.sv
// Free-running divider producing a one-cycle tick every DIV clocks.
module seq_tick_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

endmodule

// File: rtl/seq_oneshot.sv
// One delay timer: exponent prescaler followed by a mantissa counter.
module seq_oneshot
  import seq_tmr_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   start_i,
  input  logic [EXP_W+MAN_W-1:0] code_i,
  output logic                   done_o
);

  localparam int CODE_W = EXP_W + MAN_W;
  localparam int PRE_W  = (1 << EXP_W) - 1;  // bits for the widest exponent
  localparam int CNT_W  = MAN_W + 1;         // holds 2^MAN_W + m - 1

  tmr_state_e       state_q, state_d;
  logic             start_q;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic [MAN_W-1:0] man_q, man_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             rise;
  logic [PRE_W-1:0] pre_lim;
  logic [CNT_W-1:0] cnt_lim;
  logic             pre_wrap;
  logic             cnt_last;

  assign rise     = start_i & ~start_q;
  assign pre_lim  = ~({PRE_W{1'b1}} << exp_q);
  assign cnt_lim  = CNT_W'({MAN_W{1'b1}}) + CNT_W'(man_q);
  assign pre_wrap = (pre_q == pre_lim);
  assign cnt_last = (cnt_q == cnt_lim);

  always_comb begin
    state_d = state_q;
    exp_d   = exp_q;
    man_d   = man_q;
    pre_d   = pre_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      TS_IDLE: begin
        if (rise) begin
          state_d = TS_RUN;
          exp_d   = code_i[CODE_W-1 -: EXP_W];
          man_d   = code_i[MAN_W-1:0];
          pre_d   = '0;
          cnt_d   = '0;
        end
      end
      TS_RUN: begin
        if (!start_i) begin
          state_d = TS_IDLE;
        end else if (tick_i) begin
          if (pre_wrap) begin
            pre_d = '0;
            if (cnt_last) state_d = TS_DONE;
            else          cnt_d   = cnt_q + CNT_W'(1);
          end else begin
            pre_d = pre_q + PRE_W'(1);
          end
        end
      end
      TS_DONE: begin
        if (!start_i) state_d = TS_IDLE;
      end
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      start_q <= 1'b0;
      exp_q   <= '0;
      man_q   <= '0;
      pre_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_i;
      exp_q   <= exp_d;
      man_q   <= man_d;
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
    end
  end

  assign done_o = (state_q == TS_DONE);

endmodule

// File: rtl/seq_timer_bank.sv
// Bank of independent sequencing delay timers on one shared tick.
module seq_timer_bank #(
  parameter int NUM_TMR  = 4,
  parameter int TICK_DIV = 32,
  parameter int EXP_W    = 4,
  parameter int MAN_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_TMR-1:0]                 start_i,
  input  logic [NUM_TMR*(EXP_W+MAN_W)-1:0]   code_i,
  output logic [NUM_TMR-1:0]                 done_o
);

  localparam int CODE_W = EXP_W + MAN_W;

  logic srst_n;
  logic tick;

  seq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  seq_tick_div #(
    .DIV (TICK_DIV)
  ) u_tick (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick_o (tick)
  );

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    seq_oneshot #(
      .EXP_W (EXP_W),
      .MAN_W (MAN_W)
    ) u_shot (
      .clk     (clk),
      .rst_n   (srst_n),
      .tick_i  (tick),
      .start_i (start_i[gi]),
      .code_i  (code_i[gi*CODE_W +: CODE_W]),
      .done_o  (done_o[gi])
    );
  end

endmodule

// File: rtl/seq_timer_bank_chk.sv
module seq_timer_bank_chk #(
  parameter int NUM_TMR  = 4,
  parameter int TICK_DIV = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [NUM_TMR-1:0] start,
  input logic [NUM_TMR-1:0] done
);

  localparam int GW = $clog2(TICK_DIV + 1) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q) |-> (gap_q == GW'(TICK_DIV - 1)));  // R1

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_chk
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !start[gi] |=> !done[gi]);  // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done[gi] && start[gi]) |=> done[gi]);  // R4
    AST_EXPIRY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[gi]) |-> $past(tick));  // R3
    AST_EXPIRY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[gi]) |-> $past(start[gi]));  // R3
  end

endmodule

bind seq_timer_bank seq_timer_bank_chk #(
  .NUM_TMR  (NUM_TMR),
  .TICK_DIV (TICK_DIV)
) u_chk (
  .clk   (clk),
  .rst_n (srst_n),
  .tick  (tick),
  .start (start_i),
  .done  (done_o)
);

// File: tb/test_seq_timer_bank.sv
`timescale 1ns/1ps
module test_seq_timer_bank;

  localparam int NT  = 4;
  localparam int DIV = 4;
  localparam int EW  = 3;
  localparam int MW  = 3;
  localparam int CW  = EW + MW;

  logic              clk;
  logic              rst_n;
  logic [NT-1:0]     start;
  logic [NT*CW-1:0]  code;
  logic [NT-1:0]     done;

  int checks;
  int errors;

  seq_timer_bank #(
    .NUM_TMR  (NT),
    .TICK_DIV (DIV),
    .EXP_W    (EW),
    .MAN_W    (MW)
  ) i_seq_timer_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .code_i  (code),
    .done_o  (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Interval length in ticks per R2
  function automatic int ticks_of(input logic [CW-1:0] c);
    return (8 + int'(c[MW-1:0])) << int'(c[CW-1 -: EW]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp_lo, input int exp_hi);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, exp_lo, exp_hi);
    end
  endtask

  // Counts posedges after a start driven at a negedge until done[idx] is seen.
  task automatic measure(input int idx, input int limit, input bit swap,
                         input logic [CW-1:0] new_code, output int n);
    bit found = 0;
    n = 0;
    while (!found && n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (swap && n == 1) code[idx*CW +: CW] = new_code;
      if (done[idx]) found = 1;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R2, R3, R4, R5: one interval with hold and release
  task automatic t_interval(input int idx, input logic [CW-1:0] c, input string tag);
    int n;
    int nt = ticks_of(c);
    int lo = (nt - 1) * DIV + 2;
    int hi = nt * DIV + 1;
    bit held = 1;
    code[idx*CW +: CW] = c;
    start[idx] = 1'b1;
    measure(idx, hi + 20, 0, '0, n);
    check(n >= lo && n <= hi, "R2 R3", tag, n, lo, hi);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!done[idx]) held = 0;
    end
    check(held, "R4", "done held while start high", int'(held), 1, 1);
    start[idx] = 1'b0;
    @(negedge clk);
    check(!done[idx], "R5", "done after start release", int'(done[idx]), 0, 0);
  endtask

  // R5: abort mid-interval, then full restart
  task automatic t_abort();
    int n;
    logic [CW-1:0] c = 6'b011_101;
    int nt = ticks_of(c);
    bit quiet = 1;
    code[1*CW +: CW] = c;
    start[1] = 1'b1;
    repeat (nt * DIV / 2) @(negedge clk);
    start[1] = 1'b0;
    for (int k = 0; k < nt * DIV + 20; k++) begin
      @(negedge clk);
      if (done[1]) quiet = 0;
    end
    check(quiet, "R5", "done after abort", int'(quiet), 1, 1);
    start[1] = 1'b1;
    measure(1, nt * DIV + 20, 0, '0, n);
    check(n >= (nt - 1) * DIV + 2 && n <= nt * DIV + 1, "R5", "restart interval",
          n, (nt - 1) * DIV + 2, nt * DIV + 1);
    start[1] = 1'b0;
    @(negedge clk);
  endtask

  // R7: code changed right after start has no effect
  task automatic t_capture();
    int n;
    code[2*CW +: CW] = '0;
    start[2] = 1'b1;
    measure(2, 200, 1, '1, n);
    check(n >= 7 * DIV + 2 && n <= 8 * DIV + 1, "R7", "captured code interval",
          n, 7 * DIV + 2, 8 * DIV + 1);
    start[2] = 1'b0;
    @(negedge clk);
  endtask

  // R6: four timers with different codes in parallel
  task automatic t_parallel();
    logic [CW-1:0] cs [NT];
    int rise [NT];
    cs[0] = 6'b000_000; cs[1] = 6'b000_111; cs[2] = 6'b001_000; cs[3] = 6'b010_010;
    for (int i = 0; i < NT; i++) begin
      code[i*CW +: CW] = cs[i];
      rise[i] = -1;
    end
    start = '1;
    for (int n = 1; n <= 250; n++) begin
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NT; i++)
        if (done[i] && rise[i] < 0) rise[i] = n;
    end
    for (int i = 0; i < NT; i++) begin
      int nt = ticks_of(cs[i]);
      check(rise[i] >= (nt - 1) * DIV + 2 && rise[i] <= nt * DIV + 1, "R6",
            $sformatf("parallel timer %0d", i), rise[i], (nt - 1) * DIV + 2, nt * DIV + 1);
    end
    start = '0;
    @(negedge clk);
  endtask

  // R8: reset clears done; held start re-times from release
  task automatic t_reset_held();
    int n;
    code[3*CW +: CW] = '0;
    start[3] = 1'b1;
    repeat (8 * DIV + 4) @(negedge clk);
    check(done[3], "R8", "done before reset", int'(done[3]), 1, 1);
    rst_n = 1'b0;
    #1;
    check(done == '0, "R8", "done during reset", int'(done), 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    measure(3, 200, 0, '0, n);
    check(n >= 7 * DIV + 4 && n <= 8 * DIV + 3, "R8", "interval after release",
          n, 7 * DIV + 4, 8 * DIV + 3);
    start[3] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    start  = '0;
    code   = '0;
    do_reset();
    check(done == '0, "R8", "reset state", int'(done), 0, 0);
    t_interval(0, 6'b000_000, "shortest code");       // R1 via tick spacing
    t_interval(0, 6'b000_111, "mantissa only");
    t_interval(1, 6'b011_101, "middle code");
    t_interval(2, 6'b111_111, "longest code");
    t_abort();
    t_capture();
    t_parallel();
    t_reset_held();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule